// File: doc/BRIEF.md
# Transition Interface Ownership Arbiter

This block decides which of two requestors, a software bus port or a debug test-access port, may currently drive a shared set of state-transition registers. A requestor takes ownership by writing an 8-bit multibit boolean to its claim register. It gives ownership back by writing zero. Each port reads back TRUE only while it holds ownership. While a claim is held and no transition is running, hardware raises a write enable. That enable gates every write to the transition registers: the start command, the clock-control bit, the target state, the vendor test word and the token words.

The transition engine is not part of this block. It is represented by a busy input. While busy is high the write enable drops, even with a claim held, so that nothing changes under a running transition. Writes to the claim registers themselves stay possible during busy. Bus protocol decoding is also outside the block: each port presents a plain write strobe, a register index and data.

Top module: `xfer_if_mutex`

## Requirements
- R1: After reset both claim readbacks are 8'h69 (FALSE), the write enable is 0, `start_o` is 0, and the control bit, target, vendor test and token registers are all 0.
- R2: When no requestor owns the interface, a claim write of exactly 8'h96 (TRUE) makes that port the owner from the next cycle on, and its readback becomes 8'h96. A claim write of any other value leaves the interface unowned. A port that is not the owner always reads 8'h69.
- R3: A claim write from one port while the other port owns the interface has no effect. The losing port keeps reading 8'h69.
- R4: If both ports write 8'h96 in the same cycle while the interface is unowned, the software port becomes the owner.
- R5: The owner releases the interface by writing 8'h00 to its claim register. An owner writing any other value keeps ownership. A write of 8'h00 from the non-owner is ignored.
- R6: `wen_o` is 1 exactly when some port owns the interface and `busy_i` is 0. It follows `busy_i` within the same cycle.
- R7: Register index map for writes: 0 = start, 1 = control, 2 = target (low TGT_W bits), 3 = vendor test, 4 + k = token word k. A register write takes effect at the next edge only when it comes from the owning port and `wen_o` is 1. Any other register write is ignored.
- R8: The control bit can only be set. An accepted write to index 1 with data bit 0 at 1 sets it. Writing 0 has no effect. Only reset clears it.
- R9: An accepted write to index 0 with data bit 0 at 1 produces a single-cycle pulse on `start_o` in the next cycle. Every other case leaves `start_o` at 0.
- R10: Claim and release writes take effect regardless of `busy_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| busy_i | input | 1 | Transition engine is running |
| sw_claim_we_i | input | 1 | Software claim register write strobe |
| sw_claim_wdata_i | input | 8 | Software claim write value |
| sw_claim_rdata_o | output | 8 | Software claim readback |
| tap_claim_we_i | input | 1 | Debug port claim register write strobe |
| tap_claim_wdata_i | input | 8 | Debug port claim write value |
| tap_claim_rdata_o | output | 8 | Debug port claim readback |
| sw_reg_we_i | input | 1 | Software transition register write strobe |
| sw_reg_idx_i | input | IDX_W | Software register index |
| sw_reg_wdata_i | input | DW | Software register write data |
| tap_reg_we_i | input | 1 | Debug port transition register write strobe |
| tap_reg_idx_i | input | IDX_W | Debug port register index |
| tap_reg_wdata_i | input | DW | Debug port register write data |
| wen_o | output | 1 | Hardware-managed transition register write enable |
| start_o | output | 1 | Start command pulse |
| ctrl_o | output | 1 | Sticky clock-control bit |
| target_o | output | TGT_W | Requested target state |
| vtest_o | output | DW | Vendor test word |
| token_o | output | TOKEN_WORDS*DW | Token words, word 0 in the low bits |

## Verification
Some properties are checked on every cycle, whatever the stimulus. The software port wins an unowned contest. A holder keeps its claim until it writes zero. Busy freezes every transition register. A start pulse never appears unless the write enable was high. The control bit never falls back to 0. Other behaviours only show up in directed and random sequences compared against a reference model. These are: rejecting near-miss claim values, ignoring writes from the non-owner, the exact index map, and release or claim while busy.

// File: rtl/xfer_if_mutex.sv
module xfer_if_mutex #(
  parameter int TOKEN_WORDS = 4,
  parameter int DW          = 32,
  parameter int TGT_W       = 30,
  parameter logic [7:0] MB_TRUE  = 8'h96,
  parameter logic [7:0] MB_FALSE = 8'h69,
  localparam int NREGS = 4 + TOKEN_WORDS,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      busy_i,
  input  logic                      sw_claim_we_i,
  input  logic [7:0]                sw_claim_wdata_i,
  output logic [7:0]                sw_claim_rdata_o,
  input  logic                      tap_claim_we_i,
  input  logic [7:0]                tap_claim_wdata_i,
  output logic [7:0]                tap_claim_rdata_o,
  input  logic                      sw_reg_we_i,
  input  logic [IDX_W-1:0]          sw_reg_idx_i,
  input  logic [DW-1:0]             sw_reg_wdata_i,
  input  logic                      tap_reg_we_i,
  input  logic [IDX_W-1:0]          tap_reg_idx_i,
  input  logic [DW-1:0]             tap_reg_wdata_i,
  output logic                      wen_o,
  output logic                      start_o,
  output logic                      ctrl_o,
  output logic [TGT_W-1:0]          target_o,
  output logic [DW-1:0]             vtest_o,
  output logic [TOKEN_WORDS*DW-1:0] token_o
);

  typedef enum logic [1:0] {OWN_NONE = 2'b00, OWN_SW = 2'b01, OWN_TAP = 2'b10} owner_e;

  localparam logic [IDX_W-1:0] IDX_START = IDX_W'(0);
  localparam logic [IDX_W-1:0] IDX_CTRL  = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_TGT   = IDX_W'(2);
  localparam logic [IDX_W-1:0] IDX_VT    = IDX_W'(3);

  owner_e owner_q, owner_d;

  always_comb begin
    owner_d = owner_q;
    unique case (owner_q)
      OWN_NONE: begin
        if (sw_claim_we_i && sw_claim_wdata_i == MB_TRUE)        owner_d = OWN_SW;
        else if (tap_claim_we_i && tap_claim_wdata_i == MB_TRUE) owner_d = OWN_TAP;
      end
      OWN_SW:  if (sw_claim_we_i && sw_claim_wdata_i == 8'h00)   owner_d = OWN_NONE;
      OWN_TAP: if (tap_claim_we_i && tap_claim_wdata_i == 8'h00) owner_d = OWN_NONE;
      default: owner_d = OWN_NONE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) owner_q <= OWN_NONE;
    else         owner_q <= owner_d;

  assign sw_claim_rdata_o  = (owner_q == OWN_SW)  ? MB_TRUE : MB_FALSE;
  assign tap_claim_rdata_o = (owner_q == OWN_TAP) ? MB_TRUE : MB_FALSE;
  assign wen_o = (owner_q != OWN_NONE) && !busy_i;

  logic            sw_acc, tap_acc, wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [DW-1:0]    wr_data;

  assign sw_acc  = sw_reg_we_i  && wen_o && (owner_q == OWN_SW);
  assign tap_acc = tap_reg_we_i && wen_o && (owner_q == OWN_TAP);
  assign wr_en   = sw_acc || tap_acc;
  assign wr_idx  = sw_acc ? sw_reg_idx_i   : tap_reg_idx_i;
  assign wr_data = sw_acc ? sw_reg_wdata_i : tap_reg_wdata_i;

  logic start_q, ctrl_q;
  logic [TGT_W-1:0] tgt_q;
  logic [DW-1:0]    vt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      ctrl_q  <= 1'b0;
      tgt_q   <= '0;
      vt_q    <= '0;
    end else begin
      start_q <= wr_en && wr_idx == IDX_START && wr_data[0];
      if (wr_en && wr_idx == IDX_CTRL && wr_data[0]) ctrl_q <= 1'b1;
      if (wr_en && wr_idx == IDX_TGT) tgt_q <= wr_data[TGT_W-1:0];
      if (wr_en && wr_idx == IDX_VT)  vt_q  <= wr_data;
    end
  end

  for (genvar k = 0; k < TOKEN_WORDS; k++) begin : g_tok
    logic [DW-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) word_q <= '0;
      else if (wr_en && wr_idx == IDX_W'(4 + k)) word_q <= wr_data;
    assign token_o[k*DW +: DW] = word_q;
  end

  assign start_o  = start_q;
  assign ctrl_o   = ctrl_q;
  assign target_o = tgt_q;
  assign vtest_o  = vt_q;

  AST_SW_WINS_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni) // R4
    (sw_claim_we_i && sw_claim_wdata_i == MB_TRUE && sw_claim_rdata_o == MB_FALSE &&
     tap_claim_rdata_o == MB_FALSE) |=> sw_claim_rdata_o == MB_TRUE);

  AST_HOLDER_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni) // R5
    (tap_claim_rdata_o == MB_TRUE && !(tap_claim_we_i && tap_claim_wdata_i == 8'h00))
    |=> tap_claim_rdata_o == MB_TRUE);

  AST_SINGLE_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni) // R3
    !(sw_claim_rdata_o == MB_TRUE && tap_claim_rdata_o == MB_TRUE));

  AST_BUSY_FREEZES: assert property (@(posedge clk_i) disable iff (!rst_ni) // R7
    busy_i |=> ($stable(target_o) && $stable(vtest_o) && $stable(token_o) && $stable(ctrl_o)));

  AST_START_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni) // R9
    start_o |-> $past(wen_o));

  AST_CTRL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni) // R8
    ctrl_o |=> ctrl_o);

  AST_WEN_OWNED: assert property (@(posedge clk_i) disable iff (!rst_ni) // R6
    wen_o |-> (!busy_i && (sw_claim_rdata_o == MB_TRUE || tap_claim_rdata_o == MB_TRUE)));

endmodule

// File: tb/sim_xfer_if_mutex.sv
module sim_xfer_if_mutex;
  localparam int TW = 4, DW = 32, TGT_W = 30, IDX_W = 3;

  logic clk = 1'b0, rst_n = 1'b0, busy = 1'b0;
  logic sw_cwe = 1'b0, tap_cwe = 1'b0;
  logic [7:0] sw_cwd = '0, tap_cwd = '0;
  logic sw_rwe = 1'b0, tap_rwe = 1'b0;
  logic [IDX_W-1:0] sw_idx = '0, tap_idx = '0;
  logic [DW-1:0] sw_wd = '0, tap_wd = '0;
  logic [7:0] sw_rd, tap_rd;
  logic wen, start, ctrl;
  logic [TGT_W-1:0] tgt;
  logic [DW-1:0] vt;
  logic [TW*DW-1:0] tok;

  always #10 clk = ~clk;

  xfer_if_mutex u0 (
    .clk_i(clk), .rst_ni(rst_n), .busy_i(busy),
    .sw_claim_we_i(sw_cwe), .sw_claim_wdata_i(sw_cwd), .sw_claim_rdata_o(sw_rd),
    .tap_claim_we_i(tap_cwe), .tap_claim_wdata_i(tap_cwd), .tap_claim_rdata_o(tap_rd),
    .sw_reg_we_i(sw_rwe), .sw_reg_idx_i(sw_idx), .sw_reg_wdata_i(sw_wd),
    .tap_reg_we_i(tap_rwe), .tap_reg_idx_i(tap_idx), .tap_reg_wdata_i(tap_wd),
    .wen_o(wen), .start_o(start), .ctrl_o(ctrl), .target_o(tgt), .vtest_o(vt), .token_o(tok));

  int vectors = 0, miscompares = 0;
  string req = "R1";

  int m_own = 0;
  bit m_start = 0, m_ctrl = 0;
  logic [TGT_W-1:0] m_tgt = '0;
  logic [DW-1:0] m_vt = '0;
  logic [DW-1:0] m_tok [TW];

  task automatic chk(string what, logic [127:0] act, logic [127:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("sw readback",  128'(sw_rd),  128'(m_own == 1 ? 8'h96 : 8'h69));
    chk("tap readback", 128'(tap_rd), 128'(m_own == 2 ? 8'h96 : 8'h69));
    chk("write enable", 128'(wen),   128'(m_own != 0 && !busy));
    chk("start pulse",  128'(start), 128'(m_start));
    chk("control bit",  128'(ctrl),  128'(m_ctrl));
    chk("target",       128'(tgt),   128'(m_tgt));
    chk("vendor test",  128'(vt),    128'(m_vt));
    for (int k = 0; k < TW; k++) chk("token word", 128'(tok[k*DW +: DW]), 128'(m_tok[k]));
  endtask

  task automatic cyc();
    bit we_ok, acc;
    int idx;
    logic [DW-1:0] d;
    @(posedge clk);
    we_ok = (m_own != 0) && !busy;
    acc = 0; idx = 0; d = '0;
    if (m_own == 1 && sw_rwe && we_ok)  begin acc = 1; idx = sw_idx;  d = sw_wd;  end
    if (m_own == 2 && tap_rwe && we_ok) begin acc = 1; idx = tap_idx; d = tap_wd; end
    m_start = acc && idx == 0 && d[0];
    if (acc && idx == 1 && d[0]) m_ctrl = 1;
    if (acc && idx == 2) m_tgt = d[TGT_W-1:0];
    if (acc && idx == 3) m_vt = d;
    if (acc && idx >= 4 && idx < 4 + TW) m_tok[idx-4] = d;
    if (m_own == 0) begin
      if (sw_cwe && sw_cwd == 8'h96) m_own = 1;
      else if (tap_cwe && tap_cwd == 8'h96) m_own = 2;
    end else if (m_own == 1) begin
      if (sw_cwe && sw_cwd == 8'h00) m_own = 0;
    end else if (tap_cwe && tap_cwd == 8'h00) m_own = 0;
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    sw_cwe = 0; tap_cwe = 0; sw_rwe = 0; tap_rwe = 0;
  endtask

  task automatic swc(logic [7:0] v);  idle(); sw_cwe = 1;  sw_cwd = v;  cyc(); idle(); endtask
  task automatic tapc(logic [7:0] v); idle(); tap_cwe = 1; tap_cwd = v; cyc(); idle(); endtask
  task automatic swr(int i, logic [DW-1:0] v);
    idle(); sw_rwe = 1; sw_idx = IDX_W'(i); sw_wd = v; cyc(); idle();
  endtask
  task automatic tapr(int i, logic [DW-1:0] v);
    idle(); tap_rwe = 1; tap_idx = IDX_W'(i); tap_wd = v; cyc(); idle();
  endtask

  initial begin
    #2000000;
    miscompares++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int k = 0; k < TW; k++) m_tok[k] = '0;
    @(negedge clk); @(negedge clk);
    req = "R1"; compare();
    rst_n = 1'b1;
    cyc();

    req = "R2"; swc(8'h95); swc(8'h69); tapc(8'h16); swc(8'h00);
    swr(2, 32'h1234); cyc();
    swc(8'h96); cyc();
    req = "R3"; tapc(8'h96); tapc(8'h00); cyc();
    req = "R7"; swr(2, 32'hFFFF_FFFF); swr(3, 32'hA5A5_0001); swr(4, 32'h11); swr(7, 32'h44);
    tapr(5, 32'hDEAD); tapr(3, 32'h0);
    req = "R8"; swr(1, 32'h0); swr(1, 32'h1); swr(1, 32'h0); cyc();
    req = "R9"; swr(0, 32'h1); cyc(); swr(0, 32'h2); cyc(); tapr(0, 32'h1); cyc();
    req = "R6"; busy = 1; cyc();
    swr(2, 32'h5); swr(0, 32'h1); swr(6, 32'h77); cyc();
    req = "R10"; swc(8'h00); swc(8'h96); cyc();
    busy = 0; cyc();
    req = "R5"; swc(8'h69); swc(8'h01); tapc(8'h00); swc(8'h00); cyc();
    req = "R4"; idle(); sw_cwe = 1; sw_cwd = 8'h96; tap_cwe = 1; tap_cwd = 8'h96; cyc(); idle();
    swc(8'h00);
    req = "R2"; tapc(8'h96); tapr(6, 32'hBEEF); tapr(0, 32'h1); swr(6, 32'h1); cyc();
    req = "R5"; tapc(8'h00); cyc();

    req = "R7";
    for (int n = 0; n < 3000; n++) begin
      int sel;
      busy = ($urandom_range(0, 3) == 0);
      sel = $urandom_range(0, 3);
      sw_cwe = ($urandom_range(0, 4) == 0);
      sw_cwd = (sel == 0) ? 8'h96 : (sel == 1) ? 8'h00 : 8'($urandom);
      sel = $urandom_range(0, 3);
      tap_cwe = ($urandom_range(0, 4) == 0);
      tap_cwd = (sel == 0) ? 8'h96 : (sel == 1) ? 8'h00 : 8'($urandom);
      sw_rwe = $urandom_range(0, 1); sw_idx = IDX_W'($urandom); sw_wd = $urandom;
      tap_rwe = $urandom_range(0, 1); tap_idx = IDX_W'($urandom); tap_wd = $urandom;
      cyc();
    end
    idle(); busy = 0; cyc();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule